// File: doc/BRIEF.md
# Programmable Parallel Port with Strobed Handshake

This block is a parallel I/O peripheral on a small synchronous CPU bus. The bus has an 8-bit data path, a two-bit register address, a chip select, and separate read and write strobes. Three 8-bit ports face the outside: A, B and C. Port C is split into an upper nibble (bits 7:4) and a lower nibble (bits 3:0). The block does not drive pads directly. Every port has an output value and an output-enable, and the pad ring builds the tri-state buffers from them.

A write-only control register takes two kinds of word. A configuration word selects, for ports A and B, either plain unhandshaked I/O or strobed single-handshake I/O, and sets each port's direction. A single-bit command sets or clears one port C bit. In strobed mode, several port C pins become handshake lines: a strobe or acknowledge input from the peripheral, a buffer-full flag, and an interrupt request. In that mode a read of port C returns a status word that carries those flags together with the interrupt enables. Software uses the block by polling this status word, or by waiting for an interrupt pin, before it reads or writes a port.

The strobe and acknowledge pins are asynchronous to the bus clock. They are synchronized inside the block before their edges drive the handshake state.

Top module: `strobed_pio`

## Requirements
- R1: After reset, all ports are inputs in simple mode. All output-enables are 0, all output latches are 0, all buffer-full, interrupt and enable state is cleared, and a read of port A returns the pins.
- R2: A write to address 3 with bit 7 = 1 is a configuration word. Bits 6:5 are the port A mode, bit 4 is port A direction, bit 3 is port C upper direction, bit 2 is the port B mode (1 = strobed), bit 1 is port B direction and bit 0 is port C lower direction. A direction bit of 1 means input. The word clears all output latches, input latches, flags and enables.
- R3: In simple mode, a port configured as output drives its write latch with output-enable 1. A read of an input port returns its pins, and a read of an output port returns its latch. The two port C nibbles follow their own direction bits.
- R4: A write to address 3 with bit 7 = 0 sets port C latch bit wrData[3:1] to wrData[0]. Bits 6:4 are ignored and no other latch bit changes.
- R5: Addresses 0, 1 and 2 select ports A, B and C. A read of address 3 returns 0.
- R6: A port A mode field of 10 or 11 behaves as simple mode.
- R7: In port A strobed input mode (mode 01, bit 4 = 1), PC4 is an undriven active-low strobe input. The strobe falling captures port A pins into an input latch and drives PC5 (buffer full) high. Port A reads return the captured byte, and CPU writes to port A are ignored.
- R8: In port A strobed input mode, PC3 rises when the strobe returns high while buffer full and the enable are both set. The first cycle of a port A read clears PC3. The cycle after the read ends clears PC5.
- R9: In port A strobed output mode (mode 01, bit 4 = 0), a write to port A drives PC7 low and clears PC3. PC6 going low (acknowledge) returns PC7 high. PC6 returning high with the enable set raises PC3.
- R10: In port B strobed mode, PC2 is the strobe or acknowledge input and PC0 is the interrupt. PC1 is buffer full active high for input, or active low for output. The behaviour matches R7 to R9 with port B data.
- R11: Single-bit commands to PC4 (port A input), PC6 (port A output) and PC2 (port B) write the interrupt enables instead of the latch. Clearing an enable drops a pending interrupt and blocks new ones. In strobed mode, a port C read shows each enable at its bit position, and the interrupt and buffer-full pin levels at theirs.
- R12: Buffer-full reacts to a strobe edge on the third rising clock edge after the pin changes, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, active high, may span cycles |
| wr | input | 1 | Write strobe, one cycle per write |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while cs and rd are high, 0 otherwise |
| paIn | input | 8 | Port A pins |
| paOut | output | 8 | Port A output value |
| paOe | output | 1 | Port A output-enable |
| pbIn | input | 8 | Port B pins |
| pbOut | output | 8 | Port B output value |
| pbOe | output | 1 | Port B output-enable |
| pcIn | input | 8 | Port C pins |
| pcOut | output | 8 | Port C output values |
| pcOe | output | 8 | Port C per-bit output-enables |

## Verification
Plain I/O is driven with random configuration words, port writes, bit commands and pin values, and is compared with a bench model. This separates the two port C nibbles and shows that the ignored command bits have no effect. Directed handshake sequences then run strobed input on port A, strobed output on port A and both directions on port B. The input sequence places the read start and read end on different cycles, which exposes the order in which the interrupt and buffer-full clear. The sequences repeat with the enable cleared to tell a gated interrupt from one that is always raised. Sampling the flag one cycle before and one cycle after the expected edge pins down the synchronizer latency.

// File: rtl/strobed_pio_pkg.sv
package strobed_pio_pkg;

  // Field order follows bits 6:0 of the configuration word
  typedef struct packed {
    logic [1:0] aMode;
    logic       aIn;
    logic       cUpIn;
    logic       bMode;
    logic       bIn;
    logic       cLoIn;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{aMode: 2'b00, aIn: 1'b1, cUpIn: 1'b1,
                                 bMode: 1'b0, bIn: 1'b1, cLoIn: 1'b1};

  localparam int PC_W = 8;

  // Control-to-datapath strobes
  typedef struct packed {
    logic       ldA;
    logic       ldB;
    logic       ldC;
    logic       capA;
    logic       capB;
    logic       bsrEn;
    logic [2:0] bsrIdx;
    logic       bsrVal;
    logic       clrAll;
  } strobe_t;

  // Handshake state per port
  typedef struct packed {
    logic aFull;
    logic aIntr;
    logic aInte;
    logic bFull;
    logic bIntr;
    logic bInte;
  } hs_t;

  function automatic logic aHandshake(input cfg_t c);
    return c.aMode == 2'b01;
  endfunction

  function automatic logic bHandshake(input cfg_t c);
    return c.bMode;
  endfunction

endpackage

// File: rtl/strobed_pio_sync.sv
module strobed_pio_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] stage [STAGES];
  logic [WIDTH-1:0] last;
  logic [WIDTH-1:0] settled;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '1;
      last <= '1;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
      last <= stage[STAGES-1];
    end
  end

  assign settled = stage[STAGES-1];
  assign rise    = settled & ~last;
  assign fall    = last & ~settled;

endmodule

// File: rtl/strobed_pio_ctrl.sv
module strobed_pio_ctrl
  import strobed_pio_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wrData,
  input  logic [2:0]    hsPins,   // {PC6, PC4, PC2}
  output cfg_t          cfg,
  output strobe_t       stb,
  output hs_t           hs
);

  localparam int NCH = 2;   // channel 0 = port A, channel 1 = port B

  cfg_t cfgQ;
  logic wrCyc, rdCyc, wrCtl, modeWr, bsrWr, aHs, bHs, bsrVal;
  logic [2:0] bsrIdx, pinRise, pinFall;
  logic [NCH-1:0] chHs, chIn, chRise, chFall, wrPort, rdSel, rdSelQ;
  logic [NCH-1:0] rdStart, rdEnd, bsrInte;
  logic [NCH-1:0] full, intr, inte, fullNext, intrNext, inteNext;

  strobed_pio_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (hsPins),
    .rise (pinRise),
    .fall (pinFall)
  );

  assign wrCyc  = cs && wr && !rd;
  assign rdCyc  = cs && rd && !wr;
  assign wrCtl  = wrCyc && (addr == 2'd3);
  assign modeWr = wrCtl && wrData[7];
  assign bsrWr  = wrCtl && !wrData[7];
  assign bsrIdx = wrData[3:1];
  assign bsrVal = wrData[0];
  assign aHs    = aHandshake(cfgQ);
  assign bHs    = bHandshake(cfgQ);

  assign chHs   = {bHs, aHs};
  assign chIn   = {cfgQ.bIn, cfgQ.aIn};
  assign chRise = {pinRise[0], cfgQ.aIn ? pinRise[1] : pinRise[2]};
  assign chFall = {pinFall[0], cfgQ.aIn ? pinFall[1] : pinFall[2]};
  assign wrPort = {wrCyc && (addr == 2'd1), wrCyc && (addr == 2'd0)};
  assign rdSel  = {rdCyc && (addr == 2'd1), rdCyc && (addr == 2'd0)};
  assign rdStart = rdSel & ~rdSelQ;
  assign rdEnd   = rdSelQ & ~rdSel;

  assign bsrInte[0] = bsrWr && aHs && (bsrIdx == (cfgQ.aIn ? 3'd4 : 3'd6));
  assign bsrInte[1] = bsrWr && bHs && (bsrIdx == 3'd2);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      fullNext[c] = full[c];
      intrNext[c] = intr[c];
      inteNext[c] = inte[c];
      if (modeWr) begin
        fullNext[c] = 1'b0;
        intrNext[c] = 1'b0;
        inteNext[c] = 1'b0;
      end else if (chHs[c]) begin
        if (chIn[c]) begin
          if (chFall[c])      fullNext[c] = 1'b1;
          else if (rdEnd[c])  fullNext[c] = 1'b0;
          if (rdStart[c])     intrNext[c] = 1'b0;
          else if (chRise[c] && full[c] && inte[c]) intrNext[c] = 1'b1;
        end else begin
          if (wrPort[c]) begin
            fullNext[c] = 1'b1;
            intrNext[c] = 1'b0;
          end else begin
            if (chFall[c]) fullNext[c] = 1'b0;
            if (chRise[c] && !full[c] && inte[c]) intrNext[c] = 1'b1;
          end
        end
        if (bsrInte[c]) begin
          inteNext[c] = bsrVal;
          if (!bsrVal) intrNext[c] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= CFG_RESET;
      rdSelQ <= '0;
      full   <= '0;
      intr   <= '0;
      inte   <= '0;
    end else begin
      if (modeWr) cfgQ <= cfg_t'(wrData[6:0]);
      rdSelQ <= rdSel;
      full   <= fullNext;
      intr   <= intrNext;
      inte   <= inteNext;
    end
  end

  always_comb begin
    stb        = '0;
    stb.ldA    = wrPort[0] && !(aHs && cfgQ.aIn);
    stb.ldB    = wrPort[1] && !(bHs && cfgQ.bIn);
    stb.ldC    = wrCyc && (addr == 2'd2);
    stb.capA   = aHs && cfgQ.aIn && chFall[0];
    stb.capB   = bHs && cfgQ.bIn && chFall[1];
    stb.bsrEn  = bsrWr && (bsrInte == '0);
    stb.bsrIdx = bsrIdx;
    stb.bsrVal = bsrVal;
    stb.clrAll = modeWr;
  end

  assign cfg = cfgQ;
  assign hs  = '{aFull: full[0], aIntr: intr[0], aInte: inte[0],
                 bFull: full[1], bIntr: intr[1], bInte: inte[1]};

endmodule

// File: rtl/strobed_pio_dp.sv
module strobed_pio_dp
  import strobed_pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  cfg_t            cfg,
  input  strobe_t         stb,
  input  hs_t             hs,
  input  logic [DW-1:0]   wrData,
  input  logic [1:0]      addr,
  input  logic            rdEn,
  input  logic [DW-1:0]   paIn,
  input  logic [DW-1:0]   pbIn,
  input  logic [PC_W-1:0] pcIn,
  output logic [DW-1:0]   paOut,
  output logic            paOe,
  output logic [DW-1:0]   pbOut,
  output logic            pbOe,
  output logic [PC_W-1:0] pcOut,
  output logic [PC_W-1:0] pcOe,
  output logic [DW-1:0]   rdData
);

  logic [DW-1:0]   outA, outB, inA, inB, rdA, rdB;
  logic [PC_W-1:0] outC, rdC, hsMask, hsDrive, hsVal, hsStat;
  logic            aHs, bHs;

  assign aHs = aHandshake(cfg);
  assign bHs = bHandshake(cfg);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAll) begin
      outA <= '0;
      outB <= '0;
      outC <= '0;
      inA  <= '0;
      inB  <= '0;
    end else begin
      if (stb.ldA)  outA <= wrData;
      if (stb.ldB)  outB <= wrData;
      if (stb.capA) inA  <= paIn;
      if (stb.capB) inB  <= pbIn;
      if (stb.ldC)        outC <= wrData[PC_W-1:0];
      else if (stb.bsrEn) outC[stb.bsrIdx] <= stb.bsrVal;
    end
  end

  // Port C pins taken over by the handshake
  always_comb begin
    hsMask  = '0;
    hsDrive = '0;
    hsVal   = '0;
    hsStat  = '0;
    if (aHs) begin
      hsMask[3] = 1'b1; hsDrive[3] = 1'b1;
      hsVal[3]  = hs.aIntr; hsStat[3] = hs.aIntr;
      if (cfg.aIn) begin
        hsMask[4] = 1'b1; hsStat[4] = hs.aInte;
        hsMask[5] = 1'b1; hsDrive[5] = 1'b1;
        hsVal[5]  = hs.aFull; hsStat[5] = hs.aFull;
      end else begin
        hsMask[6] = 1'b1; hsStat[6] = hs.aInte;
        hsMask[7] = 1'b1; hsDrive[7] = 1'b1;
        hsVal[7]  = !hs.aFull; hsStat[7] = !hs.aFull;
      end
    end
    if (bHs) begin
      hsMask[0] = 1'b1; hsDrive[0] = 1'b1;
      hsVal[0]  = hs.bIntr; hsStat[0] = hs.bIntr;
      hsMask[1] = 1'b1; hsDrive[1] = 1'b1;
      hsVal[1]  = cfg.bIn ? hs.bFull : !hs.bFull;
      hsStat[1] = hsVal[1];
      hsMask[2] = 1'b1; hsStat[2] = hs.bInte;
    end
  end

  for (genvar i = 0; i < PC_W; i++) begin : g_pc
    logic genOe;
    if (i >= PC_W / 2) begin : g_up
      assign genOe = !cfg.cUpIn;
    end else begin : g_lo
      assign genOe = !cfg.cLoIn;
    end
    assign pcOe[i]  = hsMask[i] ? hsDrive[i] : genOe;
    assign pcOut[i] = hsMask[i] ? hsVal[i] : outC[i];
    assign rdC[i]   = hsMask[i] ? hsStat[i] : (genOe ? outC[i] : pcIn[i]);
  end

  assign paOut = outA;
  assign pbOut = outB;
  assign paOe  = !cfg.aIn;
  assign pbOe  = !cfg.bIn;
  assign rdA   = !cfg.aIn ? outA : (aHs ? inA : paIn);
  assign rdB   = !cfg.bIn ? outB : (bHs ? inB : pbIn);

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        2'd0:    rdData = rdA;
        2'd1:    rdData = rdB;
        2'd2:    rdData = DW'(rdC);
        default: rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/strobed_pio.sv
module strobed_pio
  import strobed_pio_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cs,
  input  logic            rd,
  input  logic            wr,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wrData,
  output logic [DW-1:0]   rdData,
  input  logic [DW-1:0]   paIn,
  output logic [DW-1:0]   paOut,
  output logic            paOe,
  input  logic [DW-1:0]   pbIn,
  output logic [DW-1:0]   pbOut,
  output logic            pbOe,
  input  logic [PC_W-1:0] pcIn,
  output logic [PC_W-1:0] pcOut,
  output logic [PC_W-1:0] pcOe
);

  cfg_t    cfgQ;
  strobe_t stb;
  hs_t     hs;

  strobed_pio_ctrl #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cs     (cs),
    .rd     (rd),
    .wr     (wr),
    .addr   (addr),
    .wrData (wrData),
    .hsPins ({pcIn[6], pcIn[4], pcIn[2]}),
    .cfg    (cfgQ),
    .stb    (stb),
    .hs     (hs)
  );

  strobed_pio_dp #(.DW(DW)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cfg    (cfgQ),
    .stb    (stb),
    .hs     (hs),
    .wrData (wrData),
    .addr   (addr),
    .rdEn   (cs && rd),
    .paIn   (paIn),
    .pbIn   (pbIn),
    .pcIn   (pcIn),
    .paOut  (paOut),
    .paOe   (paOe),
    .pbOut  (pbOut),
    .pbOe   (pbOe),
    .pcOut  (pcOut),
    .pcOe   (pcOe),
    .rdData (rdData)
  );

endmodule

// File: rtl/strobed_pio_chk.sv
module strobed_pio_chk
  import strobed_pio_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            cs,
  input logic            rd,
  input logic            wr,
  input logic [1:0]      addr,
  input logic [DW-1:0]   wrData,
  input logic [DW-1:0]   rdData,
  input logic            paOe,
  input logic            pbOe,
  input logic [PC_W-1:0] pcOut,
  input logic [PC_W-1:0] pcOe,
  input cfg_t            cfg
);

  logic ctlWr, aRdSel, aStrIn, aStrOut, allPlainOut;

  assign ctlWr       = cs && wr && !rd && (addr == 2'd3);
  assign aRdSel      = cs && rd && !wr && (addr == 2'd0);
  assign aStrIn      = (cfg.aMode == 2'b01) && cfg.aIn;
  assign aStrOut     = (cfg.aMode == 2'b01) && !cfg.aIn;
  assign allPlainOut = (cfg.aMode != 2'b01) && !cfg.bMode && !cfg.cUpIn && !cfg.cLoIn;

  p_ctrl_reads_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cs && rd && (addr == 2'd3)) |-> (rdData == '0));

  p_modeset_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wrData[7]) |=> (paOe == !$past(wrData[4])) && (pbOe == !$past(wrData[1])));

  p_bsr_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !wrData[7] && allPlainOut) |=> (pcOut[$past(wrData[3:1])] == $past(wrData[0])));

  p_obf_low_after_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (aStrOut && cs && wr && !rd && (addr == 2'd0)) |=> (!pcOut[7] && pcOe[7]));

  p_intr_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (aStrIn && aRdSel && !$past(aRdSel)) |=> !pcOut[3]);

  p_strobe_pin_undriven_r7: assert property (@(posedge clk) disable iff (!rstN)
    aStrIn |-> (!pcOe[4] && pcOe[5] && pcOe[3]));

endmodule

bind strobed_pio strobed_pio_chk #(.DW(DW)) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .cs     (cs),
  .rd     (rd),
  .wr     (wr),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .paOe   (paOe),
  .pbOe   (pbOe),
  .pcOut  (pcOut),
  .pcOe   (pcOe),
  .cfg    (cfgQ)
);

// File: tb/test_strobed_pio.sv
module test_strobed_pio;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, paOut, pbOut, pcOut, pcOe;
  logic       paOe, pbOe;
  logic [7:0] paIn = '0, pbIn = '0, pcIn = 8'hFF;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  // bench model of simple mode
  logic [7:0] mA = '0, mB = '0, mC = '0;
  logic dA = 1'b1, dCu = 1'b1, dB = 1'b1, dCl = 1'b1;

  always #2 clk = ~clk;

  strobed_pio i_strobed_pio (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wrData(wrData), .rdData(rdData),
    .paIn(paIn), .paOut(paOut), .paOe(paOe),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe),
    .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    d = rdData;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] expPcOe();
    return {{4{!dCu}}, {4{!dCl}}};
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a);
    logic [7:0] oe;
    oe = expPcOe();
    case (a)
      2'd0:    return dA ? paIn : mA;
      2'd1:    return dB ? pbIn : mB;
      2'd2:    return (oe & mC) | (~oe & pcIn);
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r, v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    paIn = 8'h3C;
    @(negedge clk);

    // R1 reset state
    check("R1 paOe", paOe, 0);
    check("R1 pbOe", pbOe, 0);
    check("R1 pcOe", pcOe, 8'h00);
    check("R1 paOut", paOut, 8'h00);
    check("R1 pcOut", pcOut, 8'h00);
    busRead(2'd0, v);
    check("R1 read A pins", v, 8'h3C);

    // R2 R3 R4 R5 random simple-mode traffic
    for (int it = 0; it < 160; it++) begin
      r = 8'($urandom);
      case ($urandom % 5)
        0: begin
          busWrite(2'd3, {1'b1, 2'b00, r[4], r[3], 1'b0, r[1], r[0]});
          dA = r[4]; dCu = r[3]; dB = r[1]; dCl = r[0];
          mA = '0; mB = '0; mC = '0;
        end
        1: begin busWrite(2'd0, r); mA = r; end
        2: begin busWrite(2'd1, r); mB = r; end
        3: begin busWrite(2'd2, r); mC = r; end
        default: begin
          v = 8'($urandom);
          busWrite(2'd3, {1'b0, v[6:4], r[3:1], r[0]});   // R4 bits 6:4 random
          mC[r[3:1]] = r[0];
        end
      endcase
      paIn = 8'($urandom); pbIn = 8'($urandom); pcIn = 8'($urandom);
      @(negedge clk);
      check("R3 paOut", paOut, mA);
      check("R2 paOe", paOe, !dA);
      check("R3 pbOut", pbOut, mB);
      check("R2 pbOe", pbOe, !dB);
      check("R4 pcOut", pcOut, mC);
      check("R3 pcOe", pcOe, expPcOe());
      begin
        logic [1:0] a;
        a = 2'($urandom);
        busRead(a, v);
        check("R5 read", v, expRead(a));
      end
    end

    // R7 R8 R11 R12 port A strobed input
    pcIn = 8'hFF; paIn = 8'h00;
    waitCyc(4);
    busWrite(2'd3, 8'hB0);
    busWrite(2'd3, 8'h09);                 // enable at PC4
    busRead(2'd2, v);
    check("R11 status idle A in", v, 8'h10);
    paIn = 8'h5A;
    pcIn[4] = 1'b0;
    waitCyc(2);
    check("R12 not yet full", pcOut[5], 0);
    waitCyc(1);
    check("R12 full on third edge", pcOut[5], 1);
    check("R7 PC5 driven", pcOe[5], 1);
    check("R7 PC4 undriven", pcOe[4], 0);
    check("R8 no intr while strobe low", pcOut[3], 0);
    busWrite(2'd0, 8'hFF);                 // R7 ignored
    pcIn[4] = 1'b1;
    waitCyc(4);
    check("R8 intr after strobe high", pcOut[3], 1);
    paIn = 8'h11;
    busRead(2'd2, v);
    check("R11 status A in", v, 8'h38);
    busRead(2'd0, v);
    check("R7 read latched A", v, 8'h5A);
    check("R8 intr cleared at read start", pcOut[3], 0);
    check("R8 full held until read end", pcOut[5], 1);
    @(negedge clk);
    check("R8 full cleared after read", pcOut[5], 0);
    busWrite(2'd3, 8'h08);                 // R11 clear enable
    pcIn[4] = 1'b0; waitCyc(4);
    pcIn[4] = 1'b1; waitCyc(4);
    check("R11 full without enable", pcOut[5], 1);
    check("R11 no intr without enable", pcOut[3], 0);
    busRead(2'd0, v);
    check("R7 second capture", v, 8'h11);

    // R9 R10 R11 port A strobed output, port B strobed input
    pcIn = 8'hFF;
    waitCyc(4);
    busWrite(2'd3, 8'hA6);
    check("R9 obf idle high", pcOut[7], 1);
    check("R9 PC7 driven", pcOe[7], 1);
    check("R9 paOe", paOe, 1);
    check("R10 pbOe", pbOe, 0);
    busWrite(2'd3, 8'h0D);                 // enable at PC6
    busWrite(2'd3, 8'h05);                 // enable at PC2
    busWrite(2'd0, 8'hC3);
    check("R9 paOut", paOut, 8'hC3);
    check("R9 obf low after write", pcOut[7], 0);
    pcIn[6] = 1'b0; waitCyc(4);
    check("R9 obf high after ack", pcOut[7], 1);
    check("R9 no intr during ack", pcOut[3], 0);
    pcIn[6] = 1'b1; waitCyc(4);
    check("R9 intr after ack", pcOut[3], 1);
    busRead(2'd2, v);
    check("R11 status A out B in", v, 8'hCC);
    busWrite(2'd0, 8'h3C);
    check("R9 write clears intr", pcOut[3], 0);
    check("R9 obf low again", pcOut[7], 0);
    pbIn = 8'h77;
    pcIn[2] = 1'b0; waitCyc(4);
    check("R10 B full", pcOut[1], 1);
    pcIn[2] = 1'b1; waitCyc(4);
    check("R10 B intr", pcOut[0], 1);
    busWrite(2'd3, 8'h04);
    check("R11 clearing enable drops intr", pcOut[0], 0);
    busRead(2'd1, v);
    check("R10 read B", v, 8'h77);

    // R10 port B strobed output
    pcIn = 8'hFF;
    waitCyc(4);
    busWrite(2'd3, 8'h84);
    check("R10 B obf idle high", pcOut[1], 1);
    busWrite(2'd1, 8'h42);
    check("R10 B pbOut", pbOut, 8'h42);
    check("R10 B obf low", pcOut[1], 0);
    pcIn[2] = 1'b0; waitCyc(4);
    check("R10 B obf high after ack", pcOut[1], 1);
    pcIn[2] = 1'b1; waitCyc(4);

    // R6 mode 1x behaves as simple
    busWrite(2'd3, 8'hC0);
    check("R6 paOe", paOe, 1);
    check("R6 pcOe", pcOe, 8'hFF);
    busWrite(2'd2, 8'hA5);
    check("R6 pcOut", pcOut, 8'hA5);
    busRead(2'd3, v);
    check("R5 control reads zero", v, 8'h00);

    // R2 configuration word clears latches
    busWrite(2'd0, 8'h99);
    check("R3 paOut before clear", paOut, 8'h99);
    busWrite(2'd3, 8'h80);
    check("R2 latch cleared", paOut, 8'h00);
    check("R2 pcOut cleared", pcOut, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule